// File: doc/BRIEF.md
# Restartable Block-Copy Engine

This block moves a run of bytes from one memory region to another. The copy can be interrupted partway through without losing finished work. A caller presents a source address, a byte count and a destination address with a start pulse. The engine runs in two phases.

In the first phase it spends three cycles latching the operands into its working registers, in the order source, count, destination. In the second phase it reads one byte, writes it, and then moves both address registers forward and the count back by one. The engine checks for interrupts at each byte boundary.

If an interrupt arrives while the operands are being latched, the partial load is undone and the caller starts over. If it arrives during copying, a resume flag is set and the engine stops with its registers left at their current values. A later start with the flag set skips the operand load and carries on from those registers.

The memory side is one valid/ready byte port that carries both reads and writes. Once `mem_valid` is raised, the engine holds address, direction and write data steady until the cycle in which `mem_ready` is high. A transfer completes only in a cycle where both are high, and the memory can stall the engine for any number of cycles by keeping `mem_ready` low. Read data is taken from `mem_rdata` in the completing cycle.

Top module: `blkcopy_engine`

## Requirements
- R1: After reset the working registers are zero, the resume flag is 0, and `done`, `irq_taken` and `mem_valid` are low.
- R2: A start with the resume flag clear latches `op_src`, `op_len` and `op_dst` on three successive clock cycles, in that order. The operand inputs must be held steady for those three cycles.
- R3: An `irq_req` seen in any of the three load cycles puts all three working registers back to their values from before the start. It pulses `irq_taken` for one cycle, leaves the resume flag at 0 and makes no memory access.
- R4: Each byte is first read from the address in `cur_src` (`mem_write`=0), then written to the address in `cur_dst` (`mem_write`=1) with the byte just read. When the write handshake completes, `cur_src` and `cur_dst` each go up by one and `cur_len` goes down by one.
- R5: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` stay unchanged on the next cycle.
- R6: `irq_req` is acted on during copying only when a byte write completes and bytes remain to be copied. The engine then sets the resume flag, pulses `irq_taken` for one cycle and goes idle with its registers left at their current values. `irq_req` has no effect while a read or write is still waiting for `mem_ready`.
- R7: A start with the resume flag set skips the operand load. It ignores the operand inputs and goes straight to copying from the current register values.
- R8: When the write of the last byte completes, `done` pulses for one cycle and the resume flag is cleared. This holds even if `irq_req` is high, in which case `irq_taken` stays low.
- R9: A zero count raises `done` in the cycle after the last load cycle and makes no memory access.
- R10: A start pulse while the engine is busy is ignored.
- R11: The count register holds every value from 0 up to 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin or resume a copy when idle |
| op_src | input | AW (16) | Source address operand |
| op_len | input | LW (17) | Byte count operand |
| op_dst | input | AW (16) | Destination address operand |
| irq_req | input | 1 | Pending interrupt request |
| irq_taken | output | 1 | One-cycle pulse: engine yielded to the interrupt |
| done | output | 1 | One-cycle pulse: copy finished |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW (16) | Memory byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ready | input | 1 | Memory accepts/completes the request |
| mem_rdata | input | 8 | Read byte, valid when ready |
| cur_src | output | AW (16) | Live source register |
| cur_len | output | LW (17) | Live count register |
| cur_dst | output | AW (16) | Live destination register |
| resume | output | 1 | Resume flag: copy phase was interrupted |

## Verification
The bench raises an interrupt in the middle load cycle, after the source has already been overwritten. A design that restored only the register being loaded would be left holding a new source address.

It keeps `irq_req` high across long memory stalls. An engine that sampled it inside a pending read or write would abandon a byte halfway, and the cycle-by-cycle comparison would flag the early `irq_taken`.

On restart it drives junk operands, so an engine that reloaded them would copy the wrong region. Further runs cover an interrupt that coincides with the last byte (a wrong design leaves the resume flag stuck), a zero count (a wrong design issues a stray read), a second start while busy, and a count of 65536 (a narrow count register would truncate it to 0).

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LSRC, ST_LLEN, ST_LDST, ST_RD, ST_WR
  } bc_state_e;

  typedef enum logic [2:0] {
    RC_HOLD, RC_SNAP, RC_LSRC, RC_LLEN, RC_LDST, RC_RESTORE, RC_STEP
  } bc_regcmd_e;
endpackage

// File: rtl/blkcopy_regs.sv
module blkcopy_regs
  import blkcopy_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bc_regcmd_e    cmd,
  input  logic [AW-1:0] op_src,
  input  logic [LW-1:0] op_len,
  input  logic [AW-1:0] op_dst,
  output logic [AW-1:0] src,
  output logic [LW-1:0] len,
  output logic [AW-1:0] dst,
  output logic          len_zero,
  output logic          len_one
);
  localparam logic [LW-1:0] LenOne = LW'(1);

  logic [AW-1:0] keep_src, keep_dst;
  logic [LW-1:0] keep_len;

  // live working registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0;
      len <= '0;
      dst <= '0;
    end else begin
      unique case (cmd)
        RC_LSRC:    src <= op_src;
        RC_LLEN:    len <= op_len;
        RC_LDST:    dst <= op_dst;
        RC_RESTORE: begin
          src <= keep_src;
          len <= keep_len;
          dst <= keep_dst;
        end
        RC_STEP: begin
          src <= src + 1'b1;
          len <= len - 1'b1;
          dst <= dst + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // copy of the registers taken at start, used to undo a partial load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_src <= '0;
      keep_len <= '0;
      keep_dst <= '0;
    end else if (cmd == RC_SNAP) begin
      keep_src <= src;
      keep_len <= len;
      keep_dst <= dst;
    end
  end

  assign len_zero = (len == '0);
  assign len_one  = (len == LenOne);
endmodule

// File: rtl/blkcopy_ctrl.sv
module blkcopy_ctrl
  import blkcopy_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       irq_req,
  input  logic       mem_ready,
  input  logic       len_zero,
  input  logic       len_one,
  output bc_state_e  state,
  output bc_regcmd_e cmd,
  output logic       capture,
  output logic       resume,
  output logic       done,
  output logic       irq_taken
);
  bc_state_e nxt;
  logic set_done, set_irq, set_res, clr_res;

  always_comb begin
    nxt      = state;
    cmd      = RC_HOLD;
    capture  = 1'b0;
    set_done = 1'b0;
    set_irq  = 1'b0;
    set_res  = 1'b0;
    clr_res  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (resume) begin
            nxt = ST_RD;
          end else begin
            nxt = ST_LSRC;
            cmd = RC_SNAP;
          end
        end
      end
      ST_LSRC, ST_LLEN, ST_LDST: begin
        if (irq_req) begin
          cmd     = RC_RESTORE;
          set_irq = 1'b1;
          nxt     = ST_IDLE;
        end else if (state == ST_LSRC) begin
          cmd = RC_LSRC;
          nxt = ST_LLEN;
        end else if (state == ST_LLEN) begin
          cmd = RC_LLEN;
          nxt = ST_LDST;
        end else begin
          cmd = RC_LDST;
          if (len_zero) begin
            set_done = 1'b1;
            nxt      = ST_IDLE;
          end else begin
            nxt = ST_RD;
          end
        end
      end
      ST_RD: begin
        if (mem_ready) begin
          capture = 1'b1;
          nxt     = ST_WR;
        end
      end
      ST_WR: begin
        if (mem_ready) begin
          cmd = RC_STEP;
          if (len_one) begin
            set_done = 1'b1;
            clr_res  = 1'b1;
            nxt      = ST_IDLE;
          end else if (irq_req) begin
            set_res = 1'b1;
            set_irq = 1'b1;
            nxt     = ST_IDLE;
          end else begin
            nxt = ST_RD;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      resume    <= 1'b0;
      done      <= 1'b0;
      irq_taken <= 1'b0;
    end else begin
      state     <= nxt;
      done      <= set_done;
      irq_taken <= set_irq;
      if (clr_res)      resume <= 1'b0;
      else if (set_res) resume <= 1'b1;
    end
  end
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
  import blkcopy_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] op_src,
  input  logic [LW-1:0] op_len,
  input  logic [AW-1:0] op_dst,
  input  logic          irq_req,
  output logic          irq_taken,
  output logic          done,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ready,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] cur_src,
  output logic [LW-1:0] cur_len,
  output logic [AW-1:0] cur_dst,
  output logic          resume
);
  bc_state_e  state;
  bc_regcmd_e cmd;
  logic       capture, len_zero, len_one;
  logic [7:0] byte_q;

  blkcopy_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .irq_req   (irq_req),
    .mem_ready (mem_ready),
    .len_zero  (len_zero),
    .len_one   (len_one),
    .state     (state),
    .cmd       (cmd),
    .capture   (capture),
    .resume    (resume),
    .done      (done),
    .irq_taken (irq_taken)
  );

  blkcopy_regs #(.AW(AW), .LW(LW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .op_src   (op_src),
    .op_len   (op_len),
    .op_dst   (op_dst),
    .src      (cur_src),
    .len      (cur_len),
    .dst      (cur_dst),
    .len_zero (len_zero),
    .len_one  (len_one)
  );

  // byte held between its read and its write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (capture) byte_q <= mem_rdata;
  end

  assign mem_valid = (state == ST_RD) || (state == ST_WR);
  assign mem_write = (state == ST_WR);
  assign mem_addr  = (state == ST_WR) ? cur_dst : cur_src;
  assign mem_wdata = byte_q;
endmodule

// File: rtl/blkcopy_engine_chk.sv
module blkcopy_engine_chk #(
  parameter int AW = 16,
  parameter int LW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_taken,
  input logic          done,
  input logic          mem_valid,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata,
  input logic          mem_ready,
  input logic [AW-1:0] cur_src,
  input logic [LW-1:0] cur_len,
  input logic [AW-1:0] cur_dst,
  input logic          resume
);
  // R5
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
      && $stable(mem_write) && $stable(mem_wdata)));

  // R4
  byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && mem_ready) |=>
      ((cur_len == LW'($past(cur_len) - 1'b1))
       && (cur_src == AW'($past(cur_src) + 1'b1))
       && (cur_dst == AW'($past(cur_dst) + 1'b1))));

  // R8
  done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((cur_len == '0) && !resume && !irq_taken));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  yield_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |=> !irq_taken);

  // R6
  yield_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_taken && resume) |-> ((cur_len != '0) && !mem_valid));
endmodule

bind blkcopy_engine blkcopy_engine_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_taken (irq_taken),
  .done      (done),
  .mem_valid (mem_valid),
  .mem_write (mem_write),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .cur_src   (cur_src),
  .cur_len   (cur_len),
  .cur_dst   (cur_dst),
  .resume    (resume)
);

// File: tb/test_blkcopy_engine.sv
`timescale 1ns/1ps
module test_blkcopy_engine;
  localparam int AW = 16;
  localparam int LW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, irq_req = 1'b0, mem_ready = 1'b1;
  logic [AW-1:0] op_src = '0, op_dst = '0;
  logic [LW-1:0] op_len = '0;
  logic irq_taken, done, mem_valid, mem_write, resume;
  logic [AW-1:0] mem_addr, cur_src, cur_dst;
  logic [LW-1:0] cur_len;
  logic [7:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  blkcopy_engine #(.AW(AW), .LW(LW)) i_blkcopy_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op_src(op_src), .op_len(op_len),
    .op_dst(op_dst), .irq_req(irq_req), .irq_taken(irq_taken), .done(done),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .cur_src(cur_src), .cur_len(cur_len), .cur_dst(cur_dst), .resume(resume)
  );

  // byte memory model, 4 KiB mirrored over the address space
  logic [7:0] mem [0:4095];
  assign mem_rdata = mem[mem_addr[11:0]];
  always @(posedge clk)
    if (mem_valid && mem_write && mem_ready) mem[mem_addr[11:0]] <= mem_wdata;

  int checks = 0, bad = 0, cycles = 0, acc_cnt = 0;
  logic stall_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  // back-pressure pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= stall_mode ? lfsr[0] : 1'b1;
  end

  // ---------- behavioural reference model ----------
  int m_ph = 0;                       // 0 idle,1..3 operand loads,4 read,5 write
  int unsigned m_src = 0, m_len = 0, m_dst = 0, k_src = 0, k_len = 0, k_dst = 0;
  bit m_res = 0, m_done = 0, m_irqt = 0;
  logic [7:0] m_byte = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_src = 0; m_len = 0; m_dst = 0; k_src = 0; k_len = 0; k_dst = 0;
      m_res = 0; m_done = 0; m_irqt = 0; m_byte = '0;
    end else begin
      m_done = 0; m_irqt = 0;
      if (m_ph == 0) begin
        if (start) begin
          if (m_res) m_ph = 4;
          else begin k_src = m_src; k_len = m_len; k_dst = m_dst; m_ph = 1; end
        end
      end else if (m_ph <= 3) begin
        if (irq_req) begin
          m_src = k_src; m_len = k_len; m_dst = k_dst; m_irqt = 1; m_ph = 0;
        end else if (m_ph == 1) begin m_src = op_src; m_ph = 2; end
        else if (m_ph == 2) begin m_len = op_len; m_ph = 3; end
        else begin
          m_dst = op_dst;
          if (m_len == 0) begin m_done = 1; m_ph = 0; end else m_ph = 4;
        end
      end else if (m_ph == 4) begin
        if (mem_ready) begin m_byte = mem[m_src[11:0]]; m_ph = 5; end
      end else if (mem_ready) begin
        m_src = (m_src + 1) % 65536; m_dst = (m_dst + 1) % 65536; m_len = m_len - 1;
        if (m_len == 0) begin m_done = 1; m_res = 0; m_ph = 0; end
        else if (irq_req) begin m_res = 1; m_irqt = 1; m_ph = 0; end
        else m_ph = 4;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_valid, e_write;
      int unsigned e_addr;
      bit miss;
      e_valid = (m_ph == 4 || m_ph == 5);
      e_write = (m_ph == 5);
      e_addr  = e_write ? m_dst : m_src;
      miss = 0;
      checks++;
      if (mem_valid) acc_cnt++;
      if (mem_valid !== e_valid || (e_valid && (mem_write !== e_write || mem_addr !== AW'(e_addr)))) begin
        $display("FAIL R4/R5 mem v=%0b w=%0b a=%0h exp v=%0b w=%0b a=%0h", mem_valid, mem_write, mem_addr, e_valid, e_write, e_addr);
        miss = 1;
      end
      if (e_write && mem_wdata !== m_byte) begin
        $display("FAIL R4 wdata %0h exp %0h", mem_wdata, m_byte); miss = 1;
      end
      if (cur_src !== AW'(m_src) || cur_len !== LW'(m_len) || cur_dst !== AW'(m_dst)) begin
        $display("FAIL R2/R3/R4 regs %0h/%0d/%0h exp %0h/%0d/%0h", cur_src, cur_len, cur_dst, m_src, m_len, m_dst);
        miss = 1;
      end
      if (resume !== m_res || done !== m_done || irq_taken !== m_irqt) begin
        $display("FAIL R6/R8 res/done/irq %0b%0b%0b exp %0b%0b%0b", resume, done, irq_taken, m_res, m_done, m_irqt);
        miss = 1;
      end
      if (miss) bad++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic go(input int unsigned s, input int unsigned l, input int unsigned d);
    @(negedge clk);
    start = 1'b1; op_src = AW'(s); op_len = LW'(l); op_dst = AW'(d);
    @(negedge clk);
    start = 1'b0;
  endtask

  // wait at negedges for done or irq_taken; returns 1 for done
  task automatic wait_end(output bit was_done);
    int n;
    n = 0;
    was_done = 0;
    while (!(done || irq_taken) && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk(0, "timeout waiting for end", n, 0);
    was_done = done;
  endtask

  task automatic wait_mem();
    int n;
    n = 0;
    while (!mem_valid && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic same_bytes(input int unsigned s, input int unsigned d, input int n, input string tag);
    for (int i = 0; i < n; i++)
      chk(mem[(d + i) % 4096] === mem[(s + i) % 4096], tag, mem[(d + i) % 4096], mem[(s + i) % 4096]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_req = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
      end
    end
  end

  initial begin
    bit fin;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(cur_src == 0 && cur_len == 0 && cur_dst == 0, "R1 regs after reset", cur_len, 0);
    chk(!resume && !done && !irq_taken && !mem_valid, "R1 outputs after reset", {resume, done, irq_taken, mem_valid}, 0);

    // R2 R4 R5 plain copy under back-pressure
    stall_mode = 1'b1;
    go(16'h0100, 5, 16'h0800);
    wait_end(fin);
    chk(fin, "R8 done after plain copy", fin, 1);
    chk(cur_src == 16'h0105 && cur_dst == 16'h0805 && cur_len == 0, "R4 final registers", cur_src, 16'h0105);
    same_bytes(16'h0100, 16'h0800, 5, "R4 copied bytes");

    // R3 interrupt in the middle load cycle restores prior values
    go(16'h0200, 9, 16'h0900);
    @(negedge clk); irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0;
    chk(irq_taken, "R3 irq_taken during load", irq_taken, 1);
    chk(cur_src == 16'h0105 && cur_len == 0 && cur_dst == 16'h0805, "R3 restored registers", cur_src, 16'h0105);
    chk(!resume, "R3 resume flag stays clear", resume, 0);
    go(16'h0200, 9, 16'h0900);
    wait_end(fin);
    chk(fin, "R2 restart from scratch completes", fin, 1);
    same_bytes(16'h0200, 16'h0900, 9, "R2 copied bytes after restart");

    // R6 R7 interrupt during copy, resume with junk operands
    go(16'h0300, 6, 16'h0A00);
    wait_mem();
    irq_req = 1'b1;
    wait_end(fin);
    irq_req = 1'b0;
    chk(!fin && resume, "R6 yield sets resume", resume, 1);
    chk(cur_len == 5 && cur_src == 16'h0301 && cur_dst == 16'h0A01, "R6 live registers kept", cur_len, 5);
    go(16'h0F00, 2, 16'h0F80);
    wait_end(fin);
    chk(fin && !resume, "R7 resumed copy completes", resume, 0);
    chk(cur_src == 16'h0306 && cur_dst == 16'h0A06, "R7 operands ignored on resume", cur_src, 16'h0306);
    same_bytes(16'h0300, 16'h0A00, 6, "R7 bytes after resume");

    // R8 interrupt coinciding with the final byte
    go(16'h0400, 1, 16'h0B00);
    wait_mem();
    irq_req = 1'b1;
    wait_end(fin);
    chk(fin && !irq_taken && !resume, "R8 last byte wins over irq", {fin, irq_taken, resume}, 3'b100);
    irq_req = 1'b0;

    // R9 zero count
    acc_cnt = 0;
    go(16'h0500, 0, 16'h0C00);
    wait_end(fin);
    chk(fin, "R9 done with zero count", fin, 1);
    chk(acc_cnt == 0, "R9 no memory access", acc_cnt, 0);

    // R10 start while busy ignored
    go(16'h0600, 4, 16'h0D00);
    wait_mem();
    @(negedge clk);
    start = 1'b1; op_src = 16'h0E00; op_len = 3; op_dst = 16'h0E80;
    @(negedge clk);
    start = 1'b0;
    wait_end(fin);
    chk(fin && cur_src == 16'h0604 && cur_dst == 16'h0D04, "R10 busy start ignored", cur_src, 16'h0604);
    same_bytes(16'h0600, 16'h0D00, 4, "R10 bytes");

    // R11 full-size count
    stall_mode = 1'b0;
    go(16'h0700, 65536, 16'h0100);
    wait_mem();
    chk(cur_len == 17'h10000, "R11 count 65536 held", cur_len, 17'h10000);
    irq_req = 1'b1;
    wait_end(fin);
    irq_req = 1'b0;
    chk(!fin && cur_len == 17'hFFFF && resume, "R11 count after one byte", cur_len, 17'hFFFF);

    do_reset();
    @(negedge clk);
    chk(!resume && cur_len == 0, "R1 reset clears resume", resume, 0);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule